// File: doc/BRIEF.md
# Multiword DMA Transfer Engine

This block moves a run of 16-bit words between a word-addressed memory port and a device that uses a request/acknowledge handshake. The device raises a request line. The engine answers with an acknowledge line whose polarity can be inverted. For each word it then produces a read strobe or a write strobe with programmable setup, active, inactive, hold and pause intervals. The memory side reads or writes one word per device strobe. The word can pass through a byte exchange on the way.

Software loads a configuration (start, direction, length in words minus one, start address, byte swap, abort-on-request-drop) and a timing set while the engine is idle. The length field counts down by one per word. A finished burst leaves the field at all ones. Any other value left after the engine stops means the burst ended early. A sticky completion flag is cleared by a clear pulse and drives the interrupt line only while the interrupt enable is high. A configuration write with start low and length all ones halts and clears the engine at once.

Top module: `mwdma_engine`

## Requirements
- R1: After reset the engine is idle. The acknowledge output is 0, both strobes are 0, the completion flag and the interrupt are 0, and the remaining-length output reads all ones.
- R2: Each word runs through five intervals in order. Each interval lasts `field * 2^scale + 1` clock cycles. First the acknowledge is active before the strobe (setup). Then the strobe is active (active width) and inactive (inactive width). The acknowledge stays active for the hold interval. Finally both are released for the pause interval.
- R3: The remaining-length field decreases by one at the last active-strobe cycle of each word. When it wraps to all ones and that word's pause ends, the engine goes idle on its own.
- R4: The memory address starts at the programmed value and increases by one word per transferred word. In read direction the memory write pulse comes in the last active-strobe cycle. In write direction the memory read comes in the cycle the engine leaves the request wait, with the data returned in the same cycle.
- R5: Direction bit 1 moves memory to device: the write strobe is used and the word is presented on the device write-data output. Direction bit 0 moves device to memory: the read strobe is used.
- R6: When the swap bit is 1, bits [15:8] and [7:0] of every word are exchanged in both directions. When it is 0, words pass unchanged.
- R7: The request must be seen high for `rq_delay + 1` consecutive cycles before a word starts. This delay is never multiplied by the scale.
- R8: With abort-on-drop 0, a low request between words only holds the engine, and the transfer resumes when the request returns. With abort-on-drop 1, a low request seen between words after at least one word has moved ends the transfer. The remaining length is then left at a value other than all ones, and the completion flag is set.
- R9: The completion flag is set when a burst ends (fully or by abort-on-drop). It stays set until a clear pulse. The interrupt output equals the flag ANDed with the interrupt enable.
- R10: With the acknowledge-invert bit 1, the acknowledge output is 1 when inactive and 0 when active.
- R11: While busy, configuration writes are ignored. The one exception is a write with start 0 and length all ones: it returns the engine to idle on the next cycle with length all ones, strobes and acknowledge released, and the completion flag unchanged.
- R12: Timing writes take effect only while the engine is idle. A timing write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Start bit of the configuration write |
| cfg_dir_i | input | 1 | 1: memory to device, 0: device to memory |
| cfg_swap_i | input | 1 | Exchange bytes of each word |
| cfg_abort_drop_i | input | 1 | End transfer when request drops between words |
| cfg_size_i | input | SIZE_W | Word count minus one |
| cfg_addr_i | input | ADDR_W | Start word address |
| tim_wr_i | input | 1 | Timing write strobe |
| tim_ack_setup_i | input | TW | Acknowledge-to-strobe interval |
| tim_strobe_on_i | input | TW | Strobe active interval |
| tim_strobe_off_i | input | TW | Strobe inactive interval |
| tim_ack_hold_i | input | TW | Acknowledge hold after strobe |
| tim_pause_i | input | TW | Gap after each word |
| tim_scale_i | input | SCW | Interval multiplier exponent |
| tim_rq_delay_i | input | RQW | Request sampling delay in raw cycles |
| tim_ack_invert_i | input | 1 | Invert acknowledge polarity |
| done_clr_i | input | 1 | Clear completion flag |
| irq_en_i | input | 1 | Interrupt enable |
| busy_o | output | 1 | Transfer in progress |
| size_o | output | SIZE_W | Remaining word count minus one |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt |
| dmarq_i | input | 1 | Device request |
| dmack_o | output | 1 | Device acknowledge |
| rd_stb_o | output | 1 | Device read strobe (active high) |
| wr_stb_o | output | 1 | Device write strobe (active high) |
| dev_rdata_i | input | DW | Data from device |
| dev_wdata_o | output | DW | Data to device |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rd_o | output | 1 | Memory read, data returned same cycle |
| mem_rdata_i | input | DW | Memory read data |
| mem_wr_o | output | 1 | Memory write |
| mem_wdata_o | output | DW | Memory write data |

## Verification
The assertions assume the memory returns read data in the same cycle as the read, and that control pulses are single-cycle and free of X once reset is released. They also assume no timing write comes mid-burst and matters, since the engine ignores it. The stimulus drives every input one time unit after a rising edge and holds it across the next edge. It issues configuration and timing writes as one-cycle pulses and moves the request line only at such points. In this way each requested drop lands between words, where the engine samples it.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WAIT  = 3'd1,
        PH_SETUP = 3'd2,
        PH_ACT   = 3'd3,
        PH_INACT = 3'd4,
        PH_HOLD  = 3'd5,
        PH_PAUSE = 3'd6
    } phase_e;

    // Acknowledge is active from setup through hold.
    function automatic logic ack_phase(input phase_e p);
        return (p == PH_SETUP) || (p == PH_ACT) || (p == PH_INACT) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/mwdma_timer.sv
module mwdma_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (load_i)
            d.cnt = load_val_i;
        else if (q.cnt != '0)
            d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign zero_o = (q.cnt == '0);

    // R2: an interval counts down one per cycle
    p_timer_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && q.cnt != '0) |=> (q.cnt == CW'($past(q.cnt) - 1'b1)));

endmodule

// File: rtl/mwdma_swap.sv
module mwdma_swap #(
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic          swap_i,
    input  logic [DW-1:0] in_i,
    output logic [DW-1:0] out_o
);

    localparam int NL = DW / LW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign out_o[g*LW +: LW] = swap_i ? in_i[(NL-1-g)*LW +: LW] : in_i[g*LW +: LW];
    end

endmodule

// File: rtl/mwdma_status.sv
module mwdma_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic done_o,
    output logic irq_o
);

    typedef struct packed {
        logic done;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d = q;
        d.done = set_i | (q.done & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign irq_o  = q.done & irq_en_i;

    // R9: a clear without a simultaneous set empties the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q.done);

    // R9: completion always lands in the flag
    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q.done);

endmodule

// File: rtl/mwdma_engine.sv
module mwdma_engine
    import mwdma_pkg::*;
#(
    parameter int SIZE_W = 20,
    parameter int ADDR_W = 16,
    parameter int DW     = 16,
    parameter int TW     = 6,
    parameter int SCW    = 2,
    parameter int RQW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic              cfg_en_i,
    input  logic              cfg_dir_i,
    input  logic              cfg_swap_i,
    input  logic              cfg_abort_drop_i,
    input  logic [SIZE_W-1:0] cfg_size_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic              tim_wr_i,
    input  logic [TW-1:0]     tim_ack_setup_i,
    input  logic [TW-1:0]     tim_strobe_on_i,
    input  logic [TW-1:0]     tim_strobe_off_i,
    input  logic [TW-1:0]     tim_ack_hold_i,
    input  logic [TW-1:0]     tim_pause_i,
    input  logic [SCW-1:0]    tim_scale_i,
    input  logic [RQW-1:0]    tim_rq_delay_i,
    input  logic              tim_ack_invert_i,
    input  logic              done_clr_i,
    input  logic              irq_en_i,
    output logic              busy_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              done_o,
    output logic              irq_o,
    input  logic              dmarq_i,
    output logic              dmack_o,
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    input  logic [DW-1:0]     dev_rdata_i,
    output logic [DW-1:0]     dev_wdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              mem_wr_o,
    output logic [DW-1:0]     mem_wdata_o
);

    localparam int CW = TW + (1 << SCW) - 1;

    typedef struct packed {
        phase_e            ph;
        logic [RQW-1:0]    rqc;
        logic              dir;
        logic              swap;
        logic              abort_drop;
        logic              started;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [TW-1:0]     t_setup;
        logic [TW-1:0]     t_on;
        logic [TW-1:0]     t_off;
        logic [TW-1:0]     t_hold;
        logic [TW-1:0]     t_pause;
        logic [SCW-1:0]    t_scale;
        logic [RQW-1:0]    t_rq;
        logic              t_inv;
    } eng_t;

    eng_t d, q;

    logic          stop_req;
    logic          rq_ok;
    logic          fin;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;
    logic [DW-1:0] mem_sw;

    function automatic logic [CW-1:0] scaled(input logic [TW-1:0] f, input logic [SCW-1:0] s);
        logic [CW-1:0] w;
        w = CW'(f);
        return w << s;
    endfunction

    mwdma_timer #(.CW(CW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    mwdma_swap #(.DW(DW), .LW(8)) u_sw_mem (
        .swap_i (q.swap),
        .in_i   (mem_rdata_i),
        .out_o  (mem_sw)
    );

    mwdma_swap #(.DW(DW), .LW(8)) u_sw_dev (
        .swap_i (q.swap),
        .in_i   (dev_rdata_i),
        .out_o  (mem_wdata_o)
    );

    mwdma_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (fin),
        .clr_i    (done_clr_i),
        .irq_en_i (irq_en_i),
        .done_o   (done_o),
        .irq_o    (irq_o)
    );

    assign stop_req = cfg_wr_i && !cfg_en_i && (cfg_size_i == '1);
    assign rq_ok    = dmarq_i && (q.rqc == q.t_rq);

    always_comb begin
        d      = q;
        fin    = 1'b0;
        t_load = 1'b0;
        t_val  = '0;
        if (stop_req) begin
            d.ph   = PH_IDLE;
            d.size = '1;
        end else begin
            unique case (q.ph)
                PH_IDLE: begin
                    if (cfg_wr_i) begin
                        d.dir        = cfg_dir_i;
                        d.swap       = cfg_swap_i;
                        d.abort_drop = cfg_abort_drop_i;
                        d.size       = cfg_size_i;
                        d.addr       = cfg_addr_i;
                        if (cfg_en_i) begin
                            d.ph      = PH_WAIT;
                            d.rqc     = '0;
                            d.started = 1'b0;
                        end
                    end
                    if (tim_wr_i) begin
                        d.t_setup = tim_ack_setup_i;
                        d.t_on    = tim_strobe_on_i;
                        d.t_off   = tim_strobe_off_i;
                        d.t_hold  = tim_ack_hold_i;
                        d.t_pause = tim_pause_i;
                        d.t_scale = tim_scale_i;
                        d.t_rq    = tim_rq_delay_i;
                        d.t_inv   = tim_ack_invert_i;
                    end
                end
                PH_WAIT: begin
                    if (dmarq_i) begin
                        if (rq_ok) begin
                            d.ph   = PH_SETUP;
                            t_load = 1'b1;
                            t_val  = scaled(q.t_setup, q.t_scale);
                            if (q.dir) d.data = mem_sw;
                        end else begin
                            d.rqc = q.rqc + 1'b1;
                        end
                    end else begin
                        d.rqc = '0;
                        if (q.abort_drop && q.started) begin
                            d.ph = PH_IDLE;
                            fin  = 1'b1;
                        end
                    end
                end
                PH_SETUP: begin
                    if (t_zero) begin
                        d.ph   = PH_ACT;
                        t_load = 1'b1;
                        t_val  = scaled(q.t_on, q.t_scale);
                    end
                end
                PH_ACT: begin
                    if (t_zero) begin
                        d.ph      = PH_INACT;
                        t_load    = 1'b1;
                        t_val     = scaled(q.t_off, q.t_scale);
                        d.size    = q.size - 1'b1;
                        d.addr    = q.addr + 1'b1;
                        d.started = 1'b1;
                    end
                end
                PH_INACT: begin
                    if (t_zero) begin
                        d.ph   = PH_HOLD;
                        t_load = 1'b1;
                        t_val  = scaled(q.t_hold, q.t_scale);
                    end
                end
                PH_HOLD: begin
                    if (t_zero) begin
                        d.ph   = PH_PAUSE;
                        t_load = 1'b1;
                        t_val  = scaled(q.t_pause, q.t_scale);
                    end
                end
                PH_PAUSE: begin
                    if (t_zero) begin
                        if (q.size == '1) begin
                            d.ph = PH_IDLE;
                            fin  = 1'b1;
                        end else begin
                            d.ph  = PH_WAIT;
                            d.rqc = '0;
                        end
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.size <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.ph != PH_IDLE);
    assign size_o      = q.size;
    assign dmack_o     = ack_phase(q.ph) ^ q.t_inv;
    assign rd_stb_o    = (q.ph == PH_ACT) && !q.dir;
    assign wr_stb_o    = (q.ph == PH_ACT) && q.dir;
    assign dev_wdata_o = q.data;
    assign mem_addr_o  = q.addr;
    assign mem_rd_o    = (q.ph == PH_WAIT) && q.dir && rq_ok && !stop_req;
    assign mem_wr_o    = (q.ph == PH_ACT) && !q.dir && t_zero && !stop_req;

    // R3: within a burst the length only steps down by one
    p_size_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && size_o != $past(size_o))
        |-> (size_o == SIZE_W'($past(size_o) - 1'b1)));

    // R4: within a burst the address only steps up by one
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && mem_addr_o != $past(mem_addr_o))
        |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

    // R11: a configuration write while busy leaves the mode bits alone
    p_cfg_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cfg_wr_i && !stop_req)
        |=> ($stable(q.dir) && $stable(q.swap) && $stable(q.abort_drop)));

    // R9: completion is only reported once the engine is idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o);

endmodule

// File: tb/sim_mwdma_engine.sv
`timescale 1ns/1ps
module sim_mwdma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_en = 0, cfg_dir = 0, cfg_swap = 0, cfg_abort = 0;
    logic [19:0] cfg_size = '0;
    logic [15:0] cfg_addr = '0;
    logic        tim_wr = 0;
    logic [5:0]  t_setup = 0, t_on = 0, t_off = 0, t_hold = 0, t_pause = 0;
    logic [1:0]  t_scale = 0;
    logic [3:0]  t_rq = 0;
    logic        t_inv = 0;
    logic        done_clr = 0, irq_en = 0, dmarq = 0;
    logic        busy, done, irq, dmack, rd_stb, wr_stb, mem_rd, mem_wr;
    logic [19:0] size;
    logic [15:0] dev_rdata, dev_wdata, mem_addr, mem_rdata, mem_wdata;
    logic [15:0] cyc16 = '0;
    logic [15:0] mem  [0:255];
    logic [15:0] xmem [0:255];
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    assign dev_rdata = 16'hA5C3 ^ (cyc16 * 16'h0101);
    assign mem_rdata = mem[mem_addr[7:0]];

    mwdma_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en), .cfg_dir_i(cfg_dir), .cfg_swap_i(cfg_swap),
        .cfg_abort_drop_i(cfg_abort), .cfg_size_i(cfg_size), .cfg_addr_i(cfg_addr),
        .tim_wr_i(tim_wr), .tim_ack_setup_i(t_setup), .tim_strobe_on_i(t_on),
        .tim_strobe_off_i(t_off), .tim_ack_hold_i(t_hold), .tim_pause_i(t_pause),
        .tim_scale_i(t_scale), .tim_rq_delay_i(t_rq), .tim_ack_invert_i(t_inv),
        .done_clr_i(done_clr), .irq_en_i(irq_en),
        .busy_o(busy), .size_o(size), .done_o(done), .irq_o(irq),
        .dmarq_i(dmarq), .dmack_o(dmack), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb),
        .dev_rdata_i(dev_rdata), .dev_wdata_o(dev_wdata),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
        .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata)
    );

    always @(posedge clk) begin
        cyc16 <= cyc16 + 1'b1;
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    function automatic logic [15:0] sw16(input logic [15:0] v, input bit s);
        return s ? {v[7:0], v[15:8]} : v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_ph, m_left, m_rq, m_size, m_addr;
    bit  m_dir, m_swap, m_abort, m_started, m_done, m_fin;
    logic [15:0] m_data;
    int  k_setup, k_on, k_off, k_hold, k_pause, k_scale, k_rq;
    bit  k_inv;

    function automatic int span(input int f);
        return f * (1 << k_scale);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_rq = 0; m_size = 20'hFFFFF; m_addr = 0;
            m_dir = 0; m_swap = 0; m_abort = 0; m_started = 0; m_done = 0; m_data = '0;
            k_setup = 0; k_on = 0; k_off = 0; k_hold = 0; k_pause = 0; k_scale = 0; k_rq = 0; k_inv = 0;
        end else begin
            m_fin = 0;
            if (cfg_wr && !cfg_en && cfg_size == 20'hFFFFF) begin
                m_ph = 0; m_size = 20'hFFFFF;
            end else if (m_ph == 0) begin
                if (cfg_wr) begin
                    m_dir = cfg_dir; m_swap = cfg_swap; m_abort = cfg_abort;
                    m_size = int'(cfg_size); m_addr = int'(cfg_addr);
                    if (cfg_en) begin m_ph = 1; m_rq = 0; m_started = 0; end
                end
                if (tim_wr) begin
                    k_setup = t_setup; k_on = t_on; k_off = t_off; k_hold = t_hold;
                    k_pause = t_pause; k_scale = t_scale; k_rq = t_rq; k_inv = t_inv;
                end
            end else if (m_ph == 1) begin
                if (dmarq) begin
                    if (m_rq == k_rq) begin
                        m_ph = 2; m_left = span(k_setup);
                        if (m_dir) m_data = sw16(mem[m_addr & 255], m_swap);
                    end else m_rq++;
                end else begin
                    m_rq = 0;
                    if (m_abort && m_started) begin m_ph = 0; m_fin = 1; end
                end
            end else if (m_left != 0) begin
                m_left--;
            end else begin
                case (m_ph)
                    2: begin m_ph = 3; m_left = span(k_on); end
                    3: begin
                        m_ph = 4; m_left = span(k_off);
                        if (!m_dir) xmem[m_addr & 255] = sw16(dev_rdata, m_swap);
                        m_size = (m_size - 1) & 20'hFFFFF;
                        m_addr = (m_addr + 1) & 16'hFFFF;
                        m_started = 1;
                    end
                    4: begin m_ph = 5; m_left = span(k_hold); end
                    5: begin m_ph = 6; m_left = span(k_pause); end
                    default: begin
                        if (m_size == 20'hFFFFF) begin m_ph = 0; m_fin = 1; end
                        else begin m_ph = 1; m_rq = 0; end
                    end
                endcase
            end
            if (m_fin) m_done = 1;
            else if (done_clr) m_done = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 acknowledge", 32'(dmack), 32'((m_ph >= 2 && m_ph <= 5) ^ k_inv));
            chk("R5 read strobe", 32'(rd_stb), 32'(m_ph == 3 && !m_dir));
            chk("R5 write strobe", 32'(wr_stb), 32'(m_ph == 3 && m_dir));
            chk("R3 busy", 32'(busy), 32'(m_ph != 0));
            chk("R3 remaining length", 32'(size), 32'(m_size));
            chk("R4 address", 32'(mem_addr), 32'(m_addr));
            chk("R4 memory read", 32'(mem_rd),
                32'(m_ph == 1 && m_dir && dmarq && m_rq == k_rq && !(cfg_wr && !cfg_en && cfg_size == 20'hFFFFF)));
            chk("R4 memory write", 32'(mem_wr),
                32'(m_ph == 3 && !m_dir && m_left == 0 && !(cfg_wr && !cfg_en && cfg_size == 20'hFFFFF)));
            if (mem_wr) chk("R6 memory write data", 32'(mem_wdata), 32'(sw16(dev_rdata, m_swap)));
            if (m_ph == 3 && m_dir) chk("R6 device write data", 32'(dev_wdata), 32'(m_data));
            chk("R9 done", 32'(done), 32'(m_done));
            chk("R9 irq", 32'(irq), 32'(m_done && irq_en));
        end
    end

    // ---------------- stimulus helpers (start and end at posedge+1) ----------------
    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic cfg_pulse(input bit en, input bit dir, input bit swp, input bit ab,
                             input logic [19:0] sz, input logic [15:0] ad);
        cfg_wr = 1; cfg_en = en; cfg_dir = dir; cfg_swap = swp; cfg_abort = ab;
        cfg_size = sz; cfg_addr = ad;
        step(1);
        cfg_wr = 0;
    endtask

    task automatic tim_pulse(input int s, input int on, input int off, input int h, input int p,
                             input int sc, input int rq, input bit inv);
        tim_wr = 1; t_setup = 6'(s); t_on = 6'(on); t_off = 6'(off); t_hold = 6'(h);
        t_pause = 6'(p); t_scale = 2'(sc); t_rq = 4'(rq); t_inv = inv;
        step(1);
        tim_wr = 0;
    endtask

    task automatic clear_done();
        done_clr = 1; step(1); done_clr = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 5000) begin step(1); n++; end
        chk(tag, 32'(busy), 32'd0);
    endtask

    task automatic wait_addr(input logic [15:0] a, input string tag);
        int n = 0;
        while (mem_addr != a && n < 5000) begin step(1); n++; end
        chk(tag, 32'(mem_addr), 32'(a));
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [19:0] held;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 16'hC000 ^ 16'(i * 16'h0107);
            xmem[i] = 16'hC000 ^ 16'(i * 16'h0107);
        end
        step(4);
        rst_n = 1;
        step(1);
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 acknowledge", 32'(dmack), 0);
        chk("R1 strobes", 32'(rd_stb | wr_stb), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 length", 32'(size), 32'h000FFFFF);

        // Memory to device, four words, no swap
        tim_pulse(1, 2, 1, 0, 1, 0, 0, 0);
        irq_en = 1; dmarq = 1;
        cfg_pulse(1, 1, 0, 0, 20'd3, 16'h0010);
        wait_idle("R3 write burst finished");
        chk("R3 length all ones at end", 32'(size), 32'h000FFFFF);
        chk("R4 address after four words", 32'(mem_addr), 32'h14);
        chk("R9 done after burst", 32'(done), 1);
        chk("R9 irq with enable", 32'(irq), 1);
        irq_en = 0; step(1);
        chk("R9 irq gated off", 32'(irq), 0);
        chk("R9 done still sticky", 32'(done), 1);
        clear_done();
        chk("R9 done cleared", 32'(done), 0);

        // Device to memory, swap, scaled timing, request gap with waiting
        tim_pulse(2, 1, 0, 1, 0, 1, 2, 0);
        irq_en = 1;
        cfg_pulse(1, 0, 1, 0, 20'd3, 16'h0040);
        wait_addr(16'h0042, "R4 address reached third word");
        dmarq = 0;
        step(3);
        held = size;
        step(20);
        chk("R8 holds while request low", 32'(busy), 1);
        chk("R8 length unchanged while held", 32'(size), 32'(held));
        dmarq = 1;
        wait_idle("R8 resumed burst finished");
        chk("R3 length all ones after resume", 32'(size), 32'h000FFFFF);
        for (int i = 16'h40; i < 16'h44; i++)
            chk("R6 swapped word in memory", 32'(mem[i]), 32'(xmem[i]));
        clear_done();

        // Request sampling delay, not scaled
        tim_pulse(0, 0, 0, 0, 0, 2, 3, 0);
        dmarq = 0;
        cfg_pulse(1, 1, 0, 0, 20'd1, 16'h0020);
        step(5);
        chk("R7 no start without request", 32'(dmack), 0);
        dmarq = 1;
        step(3);
        chk("R7 still waiting after three cycles", 32'(dmack), 0);
        step(1);
        chk("R7 acknowledge after four cycles", 32'(dmack), 1);
        wait_idle("R7 burst finished");
        clear_done();

        // Inverted acknowledge, abort on request drop
        tim_pulse(1, 1, 1, 1, 1, 0, 0, 1);
        chk("R10 inactive acknowledge reads 1", 32'(dmack), 1);
        cfg_pulse(1, 1, 1, 1, 20'd5, 16'h0030);
        step(1);
        chk("R10 active acknowledge reads 0", 32'(dmack), 0);
        wait_addr(16'h0031, "R4 first word moved");
        dmarq = 0;
        wait_idle("R8 aborted burst idle");
        chk("R8 residual length", 32'(size), 32'd4);
        chk("R8 done on abort", 32'(done), 1);
        dmarq = 1;
        clear_done();

        // Ignored writes while busy, then stop
        tim_pulse(0, 3, 0, 0, 0, 0, 0, 0);
        cfg_pulse(1, 0, 0, 0, 20'd7, 16'h0050);
        step(3);
        cfg_pulse(1, 1, 1, 0, 20'd2, 16'h0099);
        chk("R11 busy after ignored write", 32'(busy), 1);
        tim_pulse(0, 0, 0, 0, 0, 0, 0, 1);
        step(4);
        chk("R11 direction kept (no write strobe)", 32'(wr_stb), 0);
        cfg_pulse(0, 0, 0, 0, 20'hFFFFF, 16'h0000);
        chk("R11 stop makes idle", 32'(busy), 0);
        chk("R11 stop sets length all ones", 32'(size), 32'h000FFFFF);
        chk("R11 stop leaves done clear", 32'(done), 0);
        chk("R12 polarity write while busy ignored", 32'(dmack), 0);
        step(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule